// File: doc/BRIEF.md
# Exclusive Reservation Monitor for a Shared Memory

This block sits in front of a small shared memory and serves several requesting masters through one request port, which takes one transaction per cycle. It lets each master run a load-linked / store-conditional sequence. An exclusive read returns the data and places a reservation on the 16-byte granule that holds the address. A later exclusive write from the same master is committed only if that reservation is still armed and covers the address being written. If it is not, the write is refused, memory keeps its contents, and the master has to repeat the whole sequence.

Several events remove a reservation. A write that changes memory and comes from a different master into the reserved granule removes it. Each master has a clear line, meant for interrupt entry, that removes it at once. A countdown drops a reservation that has gone unused for longer than a programmable number of cycles. The response to an exclusive write is formed from the memory's own commit acknowledge. It is never formed from an earlier guess.

Addresses are word indices. A granule is four consecutive words, and the granule number is the word index with its two low bits removed. Each accepted request gets exactly one response, two rising edges after it is accepted.

Top module: `excl_mon_top`

## Requirements
- R1: While reset is high `req_ready` and `rsp_valid` are low. After reset no reservation is armed, so an exclusive write from any master fails until that master has done an exclusive read.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its response appears with `rsp_valid` high after the second rising edge and carries the same `rsp_id`. Normal accesses return status 2'b00. A normal read returns the last data written to that word index.
- R3: An exclusive read returns the word's data with status 2'b01 and arms a reservation for the requesting master on granule `req_addr >> 2`.
- R4: An exclusive write succeeds when the master's reservation is armed and its granule equals the written address's granule. The word is then written and the status is 2'b01.
- R5: An exclusive write that does not meet R4 returns status 2'b10 and leaves memory unchanged.
- R6: Any exclusive write by a master, whether it succeeds or fails, disarms that master's reservation.
- R7: A write by another master that modifies memory inside an armed granule disarms that reservation. This covers a normal write and a successful exclusive write. A failed exclusive write by another master does not disarm it.
- R8: A normal write by the master that holds the reservation does not disarm it. A normal read from any master never affects any reservation.
- R9: A new exclusive read by a master replaces its earlier reservation, both the granule and the timeout age.
- R10: With `tmo_lim` = L (L ≥ 1), an exclusive write accepted d edges after the exclusive read succeeds when d ≤ L. It fails when d > L.
- R11: When `excl_clr[m]` is high on an edge, master m's reservation is disarmed. An exclusive write or exclusive read by m on that same edge leaves no armed reservation, so the write fails. The clear lines of other masters have no effect on m.
- R12: An EXOKAY status for a write is only reported after the memory has acknowledged the commit. A normal read issued right after a successful exclusive write returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tmo_lim | input | TMO_W | Reservation lifetime in cycles (≥ 1) |
| excl_clr | input | N_MASTERS | Per-master reservation clear |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | Exclusive access flag |
| req_id | input | ID_W | Issuing master |
| req_addr | input | IDX_W | Word index |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | ID_W | Master the response belongs to |
| rsp_status | output | 2 | 00 OKAY, 01 EXOKAY, 10 exclusive fail |
| rsp_data | output | DATA_W | Read data (zero for writes) |

## Verification
The memory path is first swept over every word index with normal writes and reads from rotating master IDs. This separates addressing and ID-echo faults from faults in the reservation logic. Exclusive pairs are then run for every master against every word offset inside a granule, against a neighbouring granule, and after each kind of disturbing access: normal and exclusive writes from another master, its own normal write, foreign reads, and clear pulses on its own line and on other lines. These runs show whether a reservation is killed by the right events and only by those. A grid of timeout values crossed with idle gaps places the exclusive write on each side of the expiry edge. A re-read in the middle of a gap shows that the age restarts.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  // Response codes seen on rsp_status
  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_EXFAIL = 2'b10
  } rsp_code_e;

  // Word-index bits below the granule boundary (4 words = 16 bytes)
  localparam int unsigned GRAN_WORD_BITS = 2;

endpackage

// File: rtl/excl_resv_slot.sv
module excl_resv_slot #(
  parameter int unsigned SLOT_ID = 0,
  parameter int unsigned ID_W    = 2,
  parameter int unsigned GRAN_W  = 6,
  parameter int unsigned TMO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMO_W-1:0]  lim,
  input  logic              clr,
  input  logic              acc,
  input  logic [ID_W-1:0]   acc_id,
  input  logic              acc_write,
  input  logic              acc_excl,
  input  logic [GRAN_W-1:0] acc_gran,
  input  logic              acc_commit,
  output logic              armed,
  output logic [GRAN_W-1:0] gran,
  output logic [TMO_W-1:0]  age
);

  logic              armed_q;
  logic [GRAN_W-1:0] gran_q;
  logic [TMO_W-1:0]  age_q;

  logic             own;
  logic             own_exrd;
  logic             own_exwr;
  logic             foreign_hit;
  logic [TMO_W:0]   age_nx;
  logic             expire;

  always_comb begin
    own         = acc && (acc_id == ID_W'(SLOT_ID));
    own_exrd    = own && acc_excl && !acc_write;
    own_exwr    = own && acc_excl && acc_write;
    foreign_hit = acc && !own && acc_commit && armed_q && (acc_gran == gran_q);
    age_nx      = {1'b0, age_q} + (TMO_W+1)'(1);
    expire      = armed_q && (age_nx >= {1'b0, lim});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      gran_q  <= '0;
      age_q   <= '0;
    end else if (clr || own_exwr || foreign_hit) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (own_exrd) begin
      armed_q <= 1'b1;
      gran_q  <= acc_gran;
      age_q   <= '0;
    end else if (expire) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (armed_q) begin
      age_q   <= age_nx[TMO_W-1:0];
    end
  end

  assign armed = armed_q;
  assign gran  = gran_q;
  assign age   = age_q;

endmodule

// File: rtl/excl_mem.sv
module excl_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_ack
);

  logic [DATA_W-1:0] store [DEPTH];

  // Single-port, read-first array without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        store[idx] <= wdata;
      end
      rdata <= store[idx];
    end
  end

  // Commit acknowledge: the array has taken the write on this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ack <= 1'b0;
    end else begin
      wr_ack <= en && we;
    end
  end

endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int unsigned N_MASTERS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned TMO_W     = 8,
  localparam int unsigned ID_W     = $clog2(N_MASTERS),
  localparam int unsigned IDX_W    = $clog2(DEPTH),
  localparam int unsigned GRAN_W   = IDX_W - GRAN_WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TMO_W-1:0]     tmo_lim,
  input  logic [N_MASTERS-1:0] excl_clr,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_excl,
  input  logic [ID_W-1:0]      req_id,
  input  logic [IDX_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [ID_W-1:0]      rsp_id,
  output logic [1:0]           rsp_status,
  output logic [DATA_W-1:0]    rsp_data
);

  // ---------------- request decode ----------------
  logic                              acc;
  logic [GRAN_W-1:0]                 req_gran;
  logic                              ex_ok;
  logic                              commit;
  logic [N_MASTERS-1:0]              resv_armed;
  logic [N_MASTERS-1:0][GRAN_W-1:0]  resv_gran;
  logic [N_MASTERS-1:0][TMO_W-1:0]   resv_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
    end else begin
      req_ready <= 1'b1;
    end
  end

  always_comb begin
    acc      = req_valid && req_ready;
    req_gran = req_addr[IDX_W-1:GRAN_WORD_BITS];
    ex_ok    = resv_armed[req_id] && (resv_gran[req_id] == req_gran) && !excl_clr[req_id];
    commit   = acc && req_write && (!req_excl || ex_ok);
  end

  // ---------------- reservation table ----------------
  for (genvar k = 0; k < N_MASTERS; k++) begin : g_slot
    excl_resv_slot #(
      .SLOT_ID (k),
      .ID_W    (ID_W),
      .GRAN_W  (GRAN_W),
      .TMO_W   (TMO_W)
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .lim        (tmo_lim),
      .clr        (excl_clr[k]),
      .acc        (acc),
      .acc_id     (req_id),
      .acc_write  (req_write),
      .acc_excl   (req_excl),
      .acc_gran   (req_gran),
      .acc_commit (commit),
      .armed      (resv_armed[k]),
      .gran       (resv_gran[k]),
      .age        (resv_age[k])
    );
  end

  // ---------------- target memory ----------------
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_ack;

  excl_mem #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_mem (
    .clk    (clk),
    .rst    (rst),
    .en     (acc),
    .we     (commit),
    .idx    (req_addr),
    .wdata  (req_wdata),
    .rdata  (mem_rdata),
    .wr_ack (mem_ack)
  );

  // ---------------- stage 1: decision ----------------
  logic            s1_valid;
  logic            s1_write;
  logic [ID_W-1:0] s1_id;
  rsp_code_e       s1_status;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_write  <= 1'b0;
      s1_id     <= '0;
      s1_status <= RSP_OKAY;
    end else begin
      s1_valid <= acc;
      if (acc) begin
        s1_write <= req_write;
        s1_id    <= req_id;
        if (!req_excl) begin
          s1_status <= RSP_OKAY;
        end else if (!req_write) begin
          s1_status <= RSP_EXOKAY;
        end else begin
          s1_status <= ex_ok ? RSP_EXOKAY : RSP_EXFAIL;
        end
      end
    end
  end

  // ---------------- stage 2: response from the target ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_id     <= '0;
      rsp_status <= RSP_OKAY;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_id   <= s1_id;
        rsp_data <= s1_write ? '0 : mem_rdata;
        // a write can only report EXOKAY once the array acknowledged it
        if (s1_write && (s1_status == RSP_EXOKAY) && !mem_ack) begin
          rsp_status <= RSP_EXFAIL;
        end else begin
          rsp_status <= s1_status;
        end
      end
    end
  end

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int unsigned N_MASTERS = 4,
  parameter int unsigned ID_W      = 2,
  parameter int unsigned TMO_W     = 8
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               acc,
  input logic                               req_write,
  input logic                               req_excl,
  input logic [ID_W-1:0]                    req_id,
  input logic [N_MASTERS-1:0]               excl_clr,
  input logic [TMO_W-1:0]                   tmo_lim,
  input logic [N_MASTERS-1:0]               resv_armed,
  input logic [N_MASTERS-1:0][TMO_W-1:0]    resv_age,
  input logic                               s1_valid,
  input logic                               s1_write,
  input logic                               mem_ack,
  input logic                               rsp_valid,
  input logic [1:0]                         rsp_status
);

  // R2
  rsp_after_stage_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(s1_valid));

  // R2
  stage_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> $past(acc));

  // R12
  exok_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_status == 2'b01) && $past(s1_write)) |-> $past(mem_ack));

  // R5
  fail_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_status == 2'b10)) |-> !$past(mem_ack));

  for (genvar k = 0; k < N_MASTERS; k++) begin : g_slot_chk
    // R11
    clr_disarm_chk: assert property (@(posedge clk) disable iff (rst)
      $past(excl_clr[k]) |-> !resv_armed[k]);

    // R6
    own_exwr_disarm_chk: assert property (@(posedge clk) disable iff (rst)
      $past(acc && req_write && req_excl && (req_id == ID_W'(k))) |-> !resv_armed[k]);

    // R3
    exrd_arm_chk: assert property (@(posedge clk) disable iff (rst)
      $past(acc && !req_write && req_excl && (req_id == ID_W'(k)) && !excl_clr[k])
        |-> resv_armed[k]);

    // R10
    age_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (resv_armed[k] && (tmo_lim != '0) && $stable(tmo_lim)) |-> (resv_age[k] < tmo_lim));
  end

endmodule

bind excl_mon_top excl_mon_chk #(
  .N_MASTERS (N_MASTERS),
  .ID_W      (ID_W),
  .TMO_W     (TMO_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .acc        (acc),
  .req_write  (req_write),
  .req_excl   (req_excl),
  .req_id     (req_id),
  .excl_clr   (excl_clr),
  .tmo_lim    (tmo_lim),
  .resv_armed (resv_armed),
  .resv_age   (resv_age),
  .s1_valid   (s1_valid),
  .s1_write   (s1_write),
  .mem_ack    (mem_ack),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status)
);

// File: tb/excl_mon_top_tb_top.sv
module excl_mon_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NM   = 4;
  localparam int DW   = 32;
  localparam int DEP  = 256;
  localparam int TW   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] tmo_lim = 8'd100;
  logic [NM-1:0] excl_clr = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_excl = 1'b0;
  logic [1:0]    req_id = '0;
  logic [7:0]    req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_id;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [DW-1:0] model [DEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_mon_top #(.N_MASTERS(NM), .DATA_W(DW), .DEPTH(DEP), .TMO_W(TW)) dut_i (
    .clk(clk), .rst(rst), .tmo_lim(tmo_lim), .excl_clr(excl_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_status(rsp_status), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One transaction; called at a falling edge, returns at the falling edge
  // after the response became visible.
  task automatic txn(input int id, input bit wr, input bit ex, input int addr,
                     input logic [DW-1:0] wd, input logic [NM-1:0] clrv,
                     output logic [1:0] st, output logic [DW-1:0] rd);
    req_valid = 1'b1; req_write = wr; req_excl = ex;
    req_id = 2'(id); req_addr = 8'(addr); req_wdata = wd; excl_clr = clrv;
    @(posedge clk); #1;
    req_valid = 1'b0; excl_clr = '0;
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid === 1'b1, "R2 rsp_valid", 32'(rsp_valid), 32'd1);
    check(rsp_id === 2'(id), "R2 rsp_id", 32'(rsp_id), 32'(id));
    st = rsp_status; rd = rsp_data;
  endtask

  task automatic nrd(input int id, input int addr, input string req);
    logic [1:0] st; logic [DW-1:0] rd;
    txn(id, 1'b0, 1'b0, addr, '0, '0, st, rd);
    check(st === 2'b00, {req, " read status"}, 32'(st), 32'd0);
    check(rd === model[addr], {req, " read data"}, rd, model[addr]);
  endtask

  task automatic nwr(input int id, input int addr, input logic [DW-1:0] d);
    logic [1:0] st; logic [DW-1:0] rd;
    txn(id, 1'b1, 1'b0, addr, d, '0, st, rd);
    check(st === 2'b00, "R2 write status", 32'(st), 32'd0);
    model[addr] = d;
  endtask

  task automatic ex_rd(input int id, input int addr, input logic [NM-1:0] clrv,
                       input string req);
    logic [1:0] st; logic [DW-1:0] rd;
    txn(id, 1'b0, 1'b1, addr, '0, clrv, st, rd);
    check(st === 2'b01, {req, " exrd status"}, 32'(st), 32'd1);
    check(rd === model[addr], {req, " exrd data"}, rd, model[addr]);
  endtask

  task automatic ex_wr(input int id, input int addr, input logic [DW-1:0] d,
                       input bit exp_ok, input logic [NM-1:0] clrv, input string req);
    logic [1:0] st; logic [DW-1:0] rd;
    logic [1:0] exp_st;
    exp_st = exp_ok ? 2'b01 : 2'b10;
    txn(id, 1'b1, 1'b1, addr, d, clrv, st, rd);
    check(st === exp_st, {req, " exwr status"}, 32'(st), 32'(exp_st));
    if (exp_ok) model[addr] = d;
    // R12 / R5: memory holds the committed word, or the old word after a failure
    nrd((id + 1) % NM, addr, exp_ok ? "R12" : "R5");
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1:0] st; logic [DW-1:0] rd;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    check(req_ready === 1'b0, "R1 ready in reset", 32'(req_ready), 32'd0);
    check(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    // R1: no reservation after reset (status only, memory not yet known)
    for (int m = 0; m < NM; m++) begin
      txn(m, 1'b1, 1'b1, 4 * m, 32'hDEAD0000 + 32'(m), '0, st, rd);
      check(st === 2'b10, "R1 exwr after reset", 32'(st), 32'd2);
    end

    // R2: full sweep of normal writes then reads
    for (int i = 0; i < DEP; i++) nwr(i % NM, i, (32'(i) * 32'h01010101) ^ 32'h5A5A00A5);
    for (int i = 0; i < DEP; i++) nrd((i + 2) % NM, i, "R2");

    // R3 R4 R6: every master, every word offset inside a granule
    for (int m = 0; m < NM; m++) begin
      for (int w = 0; w < 4; w++) begin
        int base;
        base = 4 * (1 + m * 4 + w);
        ex_rd(m, base + w, '0, "R3");
        ex_wr(m, base + ((w + 1) % 4), 32'hC0DE0000 + 32'(m * 16 + w), 1'b1, '0, "R4");
        ex_wr(m, base + w, 32'hBAD00000, 1'b0, '0, "R6");
      end
    end

    // R5: neighbouring granule fails, and the failure disarms (R6)
    for (int m = 0; m < NM; m++) begin
      ex_rd(m, 80 + 4 * m, '0, "R5");
      ex_wr(m, 80 + 4 * m + 4, 32'hBAD10000, 1'b0, '0, "R5");
      ex_wr(m, 80 + 4 * m, 32'hBAD20000, 1'b0, '0, "R6");
    end

    // R7 / R8 across master pairs
    for (int m = 0; m < NM; m++) begin
      for (int o = 0; o < NM; o++) begin
        int a;
        if (o == m) continue;
        a = 4 * (24 + m * 4 + o);
        // foreign normal write in the granule kills the reservation
        ex_rd(m, a, '0, "R7");
        nwr(o, a + ((m + o) % 4), 32'h11110000 + 32'(a));
        ex_wr(m, a, 32'h22220000 + 32'(a), 1'b0, '0, "R7");
        // foreign write to another granule does not
        ex_rd(m, a, '0, "R7");
        nwr(o, (a + 4) % DEP, 32'h33330000 + 32'(a));
        ex_wr(m, a, 32'h44440000 + 32'(a), 1'b1, '0, "R7");
        // foreign failed exclusive write does not
        ex_rd(m, a, '0, "R7");
        ex_wr(o, a + 1, 32'h55550000, 1'b0, '0, "R7");
        ex_wr(m, a, 32'h66660000 + 32'(a), 1'b1, '0, "R7");
        // foreign successful exclusive write does
        ex_rd(m, a, '0, "R7");
        ex_rd(o, a + 2, '0, "R7");
        ex_wr(o, a + 2, 32'h77770000 + 32'(a), 1'b1, '0, "R7");
        ex_wr(m, a, 32'h88880000, 1'b0, '0, "R7");
        // own normal write and a foreign read leave it armed
        ex_rd(m, a, '0, "R8");
        nwr(m, a + 3, 32'h99990000 + 32'(a));
        nrd(o, a, "R8");
        ex_wr(m, a + 1, 32'hAAAA0000 + 32'(a), 1'b1, '0, "R8");
      end
    end

    // R9: new exclusive read replaces the granule
    for (int m = 0; m < NM; m++) begin
      ex_rd(m, 4, '0, "R9");
      ex_rd(m, 8, '0, "R9");
      ex_wr(m, 9, 32'hBEEF0000 + 32'(m), 1'b1, '0, "R9");
      ex_rd(m, 4, '0, "R9");
      ex_rd(m, 8, '0, "R9");
      ex_wr(m, 4, 32'hBAD30000, 1'b0, '0, "R9");
    end

    // R10: write lands d = 2 + gap edges after the exclusive read
    for (int lim = 1; lim <= 6; lim++) begin
      tmo_lim = 8'(lim);
      for (int gap = 0; gap <= 6; gap++) begin
        int m;
        m = (lim + gap) % NM;
        ex_rd(m, 200 + 4 * m, '0, "R10");
        idle(gap);
        ex_wr(m, 200 + 4 * m, 32'hF0000000 + 32'(lim * 16 + gap),
              (2 + gap) <= lim, '0, "R10");
      end
    end
    // R9: a re-read restarts the age (d=4 from the second read, 8 from the first)
    tmo_lim = 8'd5;
    ex_rd(2, 240, '0, "R9");
    idle(2);
    ex_rd(2, 241, '0, "R9");
    idle(2);
    ex_wr(2, 242, 32'h12345678, 1'b1, '0, "R9");
    tmo_lim = 8'd100;

    // R11: clear lines
    for (int m = 0; m < NM; m++) begin
      int o;
      o = (m + 1) % NM;
      ex_rd(m, 160, '0, "R11");
      excl_clr = NM'(1 << m); @(negedge clk); excl_clr = '0;
      ex_wr(m, 160, 32'hBAD40000, 1'b0, '0, "R11");
      ex_rd(m, 164, '0, "R11");
      excl_clr = NM'(1 << o); @(negedge clk); excl_clr = '0;
      ex_wr(m, 164, 32'hC1EA0000 + 32'(m), 1'b1, '0, "R11");
      ex_rd(m, 168, '0, "R11");
      ex_wr(m, 168, 32'hBAD50000, 1'b0, NM'(1 << m), "R11");
      ex_rd(m, 172, NM'(1 << m), "R11");
      ex_wr(m, 172, 32'hBAD60000, 1'b0, '0, "R11");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule